// File: doc/BRIEF.md
# Shared-Line Mono Serial Audio Transmitter

This block sends one channel of 16-bit two's complement PCM audio over a single serial data line that a second copy of the block also drives. Each copy owns one half of the word-clock period. The polarity input picks the half: high claims the right channel (word clock high) and low claims the left channel (word clock low). During the other half the block lowers its output-enable so the pad can float and the partner copy can drive the line. Two such mono transmitters together therefore form one stereo stream.

The bit clock and word clock arrive as plain levels and are sampled in the block's own clock domain. Every change of the data line and of the enable happens at a falling edge of the bit clock. A slot holds 32 bit periods. The format input picks where the 16 data bits sit inside that slot. In I2S framing the data starts one bit period after the word-clock change. In right-justified signal-processor framing the least significant bit is the last bit before the next word-clock change. A parallel word is held when the load strobe is high and is moved into the shift register as the block's own slot begins.

Top module: `sport_tx`

## Requirements
- R1: While `clr` is high, `sd_o` and `sd_oe_o` are low on the next clock, and the holding word, shift register, slot counter and remembered word-clock level are all zero. After clear, the first bit-clock fall that sees the word clock high counts as a slot boundary.
- R2: The word is sent most significant bit first, bit for bit as loaded (two's complement is passed through unchanged).
- R3: `sd_o` and `sd_oe_o` change only on the clock edge that first sees the bit clock low after it was high (a bit-clock fall). Between falls they hold.
- R4: At a slot boundary `sd_oe_o` becomes `wclk_i` when `pol_i` is 1 and becomes the inverse of `wclk_i` when `pol_i` is 0. Polarity and format are sampled only at boundaries.
- R5: A slot boundary is a bit-clock fall at which `wclk_i` differs from its value at the previous fall. `sd_oe_o` never changes at any other fall.
- R6: With `fmt_i` = 1 (I2S), the falls of a slot are numbered 0 (the boundary fall) to 31. Data bit 15 appears at fall 1, and bit 15-k appears at fall 1+k for k from 0 to 15.
- R7: With `fmt_i` = 0 (right-justified), data bit 15 appears at fall 16 and bit 0 at fall 31, the last fall before the next boundary.
- R8: Inside an enabled slot, every fall outside the 16 data positions drives 0. While `sd_oe_o` is low, `sd_o` is 0.
- R9: `load_i` high copies `din_i` into the holding word at that clock. The word sent in a slot is the holding word as it stood just before that slot's boundary fall. A load at the boundary clock or later in the slot affects only the next slot.
- R10: If more than 32 falls pass without a boundary, the slot counter stops at 32. Every further fall in that slot drives 0, and `sd_oe_o` is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock of the block |
| clr | input | 1 | Synchronous active-high clear |
| bclk_i | input | 1 | Bit clock level |
| wclk_i | input | 1 | Word clock level |
| pol_i | input | 1 | Channel select: 1 right (word clock high), 0 left (word clock low) |
| fmt_i | input | 1 | Framing select: 1 I2S, 0 right-justified |
| load_i | input | 1 | Capture strobe for `din_i` |
| din_i | input | 16 | Parallel PCM word |
| sd_o | output | 1 | Serial data value |
| sd_oe_o | output | 1 | Drive enable for the shared data line |

## Verification
The case where two functions meet is a load strobe that lands on the same clock as the bit-clock fall that opens this block's slot. On that clock the holding word is both being replaced and being moved into the shift register. The bench drives `load_i` exactly on the clock of the boundary fall, and in other slots on the first fall of the slot and midway through it. Its behavioural model holds that the old word goes out and the new one waits for the next slot. A second meeting point is a clear in the middle of an active slot. The model expects the enable to drop at once and the next slot to start from an empty holding word.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;
   typedef enum logic {
      FRAME_RJ  = 1'b0,
      FRAME_I2S = 1'b1
   } frame_e;

   // first slot position carrying data for a given framing
   function automatic int unsigned data_start(input frame_e f, input int unsigned slot_len,
                                              input int unsigned word_w);
      return (f == FRAME_I2S) ? 1 : slot_len - word_w;
   endfunction
endpackage

// File: rtl/sport_edge.sv
`timescale 1ns/1ps
module sport_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic clr,
   input  logic bclk_i,
   input  logic wclk_i,
   output logic fall_o,
   output logic wclk_o
);
   logic bclk_s, bclk_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign bclk_s = bclk_i;
         assign wclk_o = wclk_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] b_chain, w_chain;
         always_ff @(posedge clk) begin
            if (clr) begin
               b_chain <= '0;
               w_chain <= '0;
            end else begin
               b_chain[0] <= bclk_i;
               w_chain[0] <= wclk_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  b_chain[i] <= b_chain[i-1];
                  w_chain[i] <= w_chain[i-1];
               end
            end
         end
         assign bclk_s = b_chain[SYNC_STAGES-1];
         assign wclk_o = w_chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) bclk_q <= 1'b0;
      else     bclk_q <= bclk_s;
   end

   assign fall_o = bclk_q & ~bclk_s;
endmodule

// File: rtl/sport_slot.sv
`timescale 1ns/1ps
module sport_slot
   import sport_pkg::*;
#(
   parameter int unsigned SLOT_LEN = 32,
   localparam int unsigned CNT_W = $clog2(SLOT_LEN + 1)
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             fall_i,
   input  logic             wclk_i,
   input  logic             pol_i,
   input  logic             fmt_i,
   output logic             bnd_o,
   output logic             xfer_o,
   output logic [CNT_W-1:0] cnt_nx_o,
   output logic             oe_nx_o,
   output frame_e           fmt_nx_o,
   output logic             oe_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_LEN);

   logic             wref_q;
   logic [CNT_W-1:0] cnt_q;
   frame_e           fmt_q;

   always_comb begin
      bnd_o    = fall_i && (wclk_i != wref_q);
      cnt_nx_o = cnt_q;
      oe_nx_o  = oe_o;
      fmt_nx_o = fmt_q;
      if (bnd_o) begin
         cnt_nx_o = '0;
         oe_nx_o  = pol_i ? wclk_i : ~wclk_i;
         fmt_nx_o = frame_e'(fmt_i);
      end else if (fall_i && cnt_q != CNT_MAX) begin
         cnt_nx_o = cnt_q + 1'b1;
      end
      xfer_o = bnd_o && oe_nx_o;
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         wref_q <= 1'b0;
         cnt_q  <= '0;
         oe_o   <= 1'b0;
         fmt_q  <= FRAME_RJ;
      end else begin
         if (fall_i) wref_q <= wclk_i;
         cnt_q <= cnt_nx_o;
         oe_o  <= oe_nx_o;
         fmt_q <= fmt_nx_o;
      end
   end

   // R10: the counter never passes the saturation point
   a_r10_cnt_bound: assert property (@(posedge clk) disable iff (clr) cnt_q <= CNT_MAX);

   // R5: between boundaries the enable holds
   a_r5_oe_only_at_bnd: assert property (@(posedge clk) disable iff (clr)
      !bnd_o |=> $stable(oe_o));

   // R10: once saturated without a boundary, the counter stays put
   a_r10_cnt_sticks: assert property (@(posedge clk) disable iff (clr)
      (cnt_q == CNT_MAX && !bnd_o) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/sport_shift.sv
`timescale 1ns/1ps
module sport_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              load_i,
   input  logic [WORD_W-1:0] din_i,
   input  logic              fall_i,
   input  logic              xfer_i,
   input  logic              win_i,
   output logic              sd_o
);
   logic [WORD_W-1:0] hold_q, shreg_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         hold_q  <= '0;
         shreg_q <= '0;
         sd_o    <= 1'b0;
      end else begin
         if (load_i) hold_q <= din_i;
         if (fall_i) begin
            if (xfer_i) begin
               shreg_q <= hold_q;
               sd_o    <= 1'b0;
            end else if (win_i) begin
               sd_o    <= shreg_q[WORD_W-1];
               shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
            end else begin
               sd_o    <= 1'b0;
            end
         end
      end
   end

   // R9: a load is taken into the holding word on that clock
   a_r9_capture: assert property (@(posedge clk) disable iff (clr)
      load_i |=> hold_q == $past(din_i));

   // R3: the data line holds between bit-clock falls
   a_r3_sd_hold: assert property (@(posedge clk) disable iff (clr)
      !fall_i |=> $stable(sd_o));
endmodule

// File: rtl/sport_tx.sv
`timescale 1ns/1ps
module sport_tx
   import sport_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SLOT_LEN    = 32,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              bclk_i,
   input  logic              wclk_i,
   input  logic              pol_i,
   input  logic              fmt_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] din_i,
   output logic              sd_o,
   output logic              sd_oe_o
);
   localparam int unsigned CNT_W = $clog2(SLOT_LEN + 1);
   localparam logic [CNT_W-1:0] I2S_START = CNT_W'(data_start(FRAME_I2S, SLOT_LEN, WORD_W));
   localparam logic [CNT_W-1:0] RJ_START  = CNT_W'(data_start(FRAME_RJ, SLOT_LEN, WORD_W));
   localparam logic [CNT_W-1:0] SPAN      = CNT_W'(WORD_W);

   generate
      if (WORD_W < 2 || WORD_W >= SLOT_LEN) begin : g_bad_width
         $error("sport_tx: WORD_W must be at least 2 and below SLOT_LEN");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("sport_tx: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic             fall, wclk_s, bnd, xfer, oe_nx, win;
   logic [CNT_W-1:0] cnt_nx, start;
   frame_e           fmt_nx;

   sport_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .clr    (clr),
      .bclk_i (bclk_i),
      .wclk_i (wclk_i),
      .fall_o (fall),
      .wclk_o (wclk_s)
   );

   sport_slot #(.SLOT_LEN(SLOT_LEN)) u_slot (
      .clk      (clk),
      .clr      (clr),
      .fall_i   (fall),
      .wclk_i   (wclk_s),
      .pol_i    (pol_i),
      .fmt_i    (fmt_i),
      .bnd_o    (bnd),
      .xfer_o   (xfer),
      .cnt_nx_o (cnt_nx),
      .oe_nx_o  (oe_nx),
      .fmt_nx_o (fmt_nx),
      .oe_o     (sd_oe_o)
   );

   always_comb begin
      start = (fmt_nx == FRAME_I2S) ? I2S_START : RJ_START;
      win   = oe_nx && (cnt_nx >= start) && (cnt_nx < start + SPAN);
   end

   sport_shift #(.WORD_W(WORD_W)) u_shift (
      .clk    (clk),
      .clr    (clr),
      .load_i (load_i),
      .din_i  (din_i),
      .fall_i (fall),
      .xfer_i (xfer),
      .win_i  (win),
      .sd_o   (sd_o)
   );

   // R1: clear silences the line on the next clock
   a_r1_clear: assert property (@(posedge clk) clr |=> (!sd_oe_o && !sd_o));

   // R8: no data while the line is released
   a_r8_quiet: assert property (@(posedge clk) disable iff (clr) !sd_oe_o |-> !sd_o);

   // R4: the enable follows the channel phase chosen at each boundary
   a_r4_phase: assert property (@(posedge clk) disable iff (clr)
      bnd |=> sd_oe_o == ($past(pol_i) ? $past(wclk_s) : !$past(wclk_s)));

   // R3: the enable holds between bit-clock falls
   a_r3_oe_hold: assert property (@(posedge clk) disable iff (clr)
      !fall |=> $stable(sd_oe_o));
endmodule

// File: tb/sport_tx_tb.sv
`timescale 1ns/1ps
module sport_tx_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        clr = 1'b1, bclk = 1'b0, wclk = 1'b0, pol = 1'b0, fmt = 1'b1, load = 1'b0;
   logic [15:0] din = '0;
   logic        sd, sd_oe;

   sport_tx u_dut (
      .clk(clk), .clr(clr), .bclk_i(bclk), .wclk_i(wclk), .pol_i(pol), .fmt_i(fmt),
      .load_i(load), .din_i(din), .sd_o(sd), .sd_oe_o(sd_oe)
   );

   int checks = 0, errors = 0;
   bit started = 0, done = 0;
   string cur_req = "R1";

   // behavioural reference
   bit m_pb, m_wref, m_oe, m_sd, m_fmt;
   int m_cnt;
   bit [15:0] m_word, m_hold;

   always @(posedge clk) begin
      started <= 1;
      if (clr) begin
         m_pb = 0; m_wref = 0; m_oe = 0; m_sd = 0; m_fmt = 0; m_cnt = 0;
         m_word = 0; m_hold = 0;
      end else begin
         if (m_pb && !bclk) begin
            if (wclk != m_wref) begin
               m_cnt = 0;
               m_oe  = pol ? wclk : !wclk;
               m_fmt = fmt;
               if (m_oe) m_word = m_hold;
            end else if (m_cnt < 32) m_cnt++;
            m_wref = wclk;
            begin
               int pos;
               pos  = m_cnt - (m_fmt ? 1 : 16);
               m_sd = (m_oe && pos >= 0 && pos < 16) ? m_word[15-pos] : 1'b0;
            end
         end
         if (load) m_hold = din;
         m_pb = bclk;
      end
      if (clr) m_pb = 0;
   end

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         check(cur_req, sd_oe, m_oe, "sd_oe_o");
         check(cur_req, sd, m_sd, "sd_o");
      end
   end

   // one bit period: fall (optionally with word-clock toggle and load), then rise
   task automatic bit_period(input bit toggle, input bit do_load, input logic [15:0] d);
      @(negedge clk); bclk = 0; if (toggle) wclk = ~wclk; load = do_load; din = d;
      @(negedge clk); load = 0;
      @(negedge clk); bclk = 1;
      @(negedge clk);
   endtask

   task automatic run_slot(input int nbits, input int load_at, input logic [15:0] d);
      for (int i = 0; i < nbits; i++) bit_period(i == 0, i == load_at, d);
   endtask

   task automatic frames(input bit p, input bit f, input logic [15:0] w0, input logic [15:0] w1);
      pol = p; fmt = f;
      run_slot(32, 7, w0);
      run_slot(32, 20, w1);
      run_slot(32, -1, 16'h0);
      run_slot(32, -1, 16'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      cur_req = "R1";
      check("R1", sd_oe, 1'b0, "reset sd_oe_o");
      check("R1", sd, 1'b0, "reset sd_o");
      clr = 0;

      cur_req = "R2 R4 R6 R9";
      frames(1, 1, 16'hA5C3, 16'h8001);
      cur_req = "R2 R4 R5 R6";
      frames(0, 1, 16'h7FFF, 16'h8000);
      cur_req = "R7 R8 R4";
      frames(1, 0, 16'h1234, 16'hFFFF);
      frames(0, 0, 16'hC0DE, 16'h0001);

      // load coinciding with the boundary fall (R9): old word must go out
      cur_req = "R9";
      pol = 1; fmt = 1;
      run_slot(32, 0, 16'h5A5A);
      run_slot(32, 0, 16'h3C3C);
      run_slot(32, 0, 16'hF00F);
      run_slot(32, 1, 16'h0FF0);

      // polarity change mid-slot is ignored until the boundary (R4)
      cur_req = "R4 R5";
      run_slot(16, -1, 0);
      pol = 0;
      for (int i = 0; i < 16; i++) bit_period(0, 0, 0);
      run_slot(32, 3, 16'h9999);
      run_slot(32, -1, 0);

      // over-long slot: counter saturates (R10)
      cur_req = "R10 R7";
      fmt = 0;
      run_slot(32, 5, 16'hBEEF);
      run_slot(45, -1, 0);
      run_slot(40, -1, 0);

      // clear in the middle of an active slot (R1)
      cur_req = "R1";
      run_slot(10, -1, 0);
      @(negedge clk); clr = 1;
      @(negedge clk);
      check("R1", sd_oe, 1'b0, "sd_oe_o after mid-slot clear");
      check("R1", sd, 1'b0, "sd_o after mid-slot clear");
      clr = 0;
      cur_req = "R1 R3 R6";
      fmt = 1; pol = 1;
      wclk = 0;
      run_slot(32, -1, 0);
      run_slot(32, -1, 0);
      run_slot(32, 2, 16'h4321);
      run_slot(32, -1, 0);
      run_slot(32, -1, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule